// File: doc/BRIEF.md
# Narrow-to-Wide Memory Reshaper

This block offers a deep memory of narrow words, with one write port and one read port, while keeping the bits in a shallow array of wide rows. Each row holds several narrow words side by side, and each of those words has its own write-enable bit. The low bits of an address choose the word's lane inside a row. The remaining high bits choose the row.

On a write, the block shifts the incoming word into the position of its lane and raises only that lane's enable bit. The other words that share the row keep their contents. On a read, the block fetches the whole row, remembers which lane was asked for, and returns that lane's slice one cycle later.

The wide masked array is modelled behaviourally inside the block. Both ports run on one clock. With the default parameters the block holds 256 words of 2 bits in 64 rows of 8 bits, which gives 4 lanes per row.

Top module: `narrow_wide_mem`

## Requirements
- R1: While reset is held and after it is released, and before any read has been made, `rd_data` is 0.
- R2: Address `a` maps to row `a >> LANE_BITS` and lane `a % LANES`, where LANES = PHYS_W / LOG_W (4 by default) and LANE_BITS = log2(LANES) (2 by default). Every one of the LOG_DEPTH addresses stores a word of its own, so writing all of them and reading them back returns each word unchanged.
- R3: A write raises exactly one lane-enable bit, the one with the lane's index, and puts the word at bit offset lane*LOG_W of the row. The other lanes of that row keep their contents.
- R4: When `wr_en` is 0, the values on `wr_addr` and `wr_data` have no effect on the stored contents.
- R5: When `rd_en` is 1 at a rising clock edge, `rd_data` shows the word stored at `rd_addr` from that edge until the next read. This is a read latency of one cycle.
- R6: While `rd_en` is 0, `rd_data` holds its last value, whatever `rd_addr` does.
- R7: A read and a write to the same address at the same edge return the contents from before the write. A later read returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset of the read output register and the lane register |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Narrow write address |
| wr_data | input | LOG_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Narrow read address |
| rd_data | output | LOG_W | Word read, valid one cycle after the request |

## Verification
The bench fills all 256 addresses with two different data patterns and reads every address back after each fill. The first pattern depends on the lane bits and the low row bits, and the second depends on the top row bits. A swapped, missing or misplaced address bit shows up in one pattern or the other. To check lane isolation, the bench first clears a row, writes one lane, and then reads all four lanes, for every lane of the first, a middle and the last row. This tells a correct one-hot mask from a broadcast write or a wrong shift. Further tests cover a write with `wr_en` low, a read output that must hold while `rd_addr` changes, and a read and write to the same address at the same edge, which shows whether the lane register and the read-first ordering line up with the array's latency.

// File: rtl/nwm_pkg.sv
package nwm_pkg;
  // number of narrow lanes packed into one wide row
  function automatic int lanes_of(input int phys_w, input int log_w);
    return phys_w / log_w;
  endfunction

  // index width for a count, never below one bit
  function automatic int index_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nwm_write_map.sv
module nwm_write_map #(
  parameter int LOG_W     = 2,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 2,
  parameter int ADDR_W    = 8,
  localparam int ROW_W    = ADDR_W - LANE_BITS,
  localparam int PW       = LOG_W * LANES
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LOG_W-1:0]  data,
  output logic [ROW_W-1:0]  row,
  output logic [PW-1:0]     wide,
  output logic [LANES-1:0]  mask
);
  function automatic logic [PW-1:0] place_word(input logic [LOG_W-1:0] d,
                                               input logic [LANE_BITS-1:0] lane);
    logic [PW-1:0] r;
    r = '0;
    r[LOG_W-1:0] = d;
    return r << (int'(lane) * LOG_W);
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_BITS-1:0] lane);
    logic [LANES-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    return m;
  endfunction

  logic [LANE_BITS-1:0] lane;

  always_comb begin
    lane = addr[LANE_BITS-1:0];
    row  = addr[ADDR_W-1:LANE_BITS];
    wide = place_word(data, lane);
    mask = wr_en ? lane_mask(lane) : '0;
  end
endmodule

// File: rtl/nwm_wide_array.sv
module nwm_wide_array #(
  parameter int GRAN     = 2,
  parameter int LANES    = 4,
  parameter int ROW_W    = 6,
  localparam int ROWS    = 1 << ROW_W,
  localparam int PW      = GRAN * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ROW_W-1:0] wrow,
  input  logic [PW-1:0]    wdata,
  input  logic [LANES-1:0] wmask,
  input  logic             re,
  input  logic [ROW_W-1:0] rrow,
  output logic [PW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [GRAN-1:0] store [ROWS];
    logic [GRAN-1:0] q;

    always_ff @(posedge clk) begin
      if (we && wmask[g]) store[wrow] <= wdata[g*GRAN +: GRAN];
    end

    // read-first: the fetch sees contents before a same-edge write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= store[rrow];
    end

    assign rdata[g*GRAN +: GRAN] = q;
  end
endmodule

// File: rtl/nwm_read_select.sv
module nwm_read_select #(
  parameter int LOG_W     = 2,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 2,
  localparam int PW       = LOG_W * LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 re,
  input  logic [LANE_BITS-1:0] lane_in,
  input  logic [PW-1:0]        row_data,
  output logic [LANE_BITS-1:0] lane_q,
  output logic [LOG_W-1:0]     word
);
  function automatic logic [LOG_W-1:0] slice_of(input logic [PW-1:0] r,
                                                input logic [LANE_BITS-1:0] lane);
    logic [PW-1:0] t;
    t = r >> (int'(lane) * LOG_W);
    return t[LOG_W-1:0];
  endfunction

  // lane index follows the row fetch by the same one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lane_q <= '0;
    else if (re) lane_q <= lane_in;
  end

  always_comb word = slice_of(row_data, lane_q);
endmodule

// File: rtl/narrow_wide_mem.sv
module narrow_wide_mem #(
  parameter int LOG_W     = 2,
  parameter int LOG_DEPTH = 256,
  parameter int PHYS_W    = 8,
  localparam int LANES     = nwm_pkg::lanes_of(PHYS_W, LOG_W),
  localparam int LANE_BITS = nwm_pkg::index_bits(LANES),
  localparam int ADDR_W    = nwm_pkg::index_bits(LOG_DEPTH),
  localparam int ROW_W     = ADDR_W - LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LOG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LOG_W-1:0]  rd_data
);
  logic [ROW_W-1:0]        wr_row;
  logic [PHYS_W-1:0]       wr_wide;
  logic [LANES-1:0]        wr_mask;
  logic [ROW_W-1:0]        rd_row;
  logic [PHYS_W-1:0]       rd_wide;
  logic [LANE_BITS-1:0]    rd_lane_q;

  assign rd_row = rd_addr[ADDR_W-1:LANE_BITS];

  nwm_write_map #(
    .LOG_W(LOG_W), .LANES(LANES), .LANE_BITS(LANE_BITS), .ADDR_W(ADDR_W)
  ) u_wmap (
    .wr_en(wr_en), .addr(wr_addr), .data(wr_data),
    .row(wr_row), .wide(wr_wide), .mask(wr_mask)
  );

  nwm_wide_array #(
    .GRAN(LOG_W), .LANES(LANES), .ROW_W(ROW_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .wrow(wr_row), .wdata(wr_wide), .wmask(wr_mask),
    .re(rd_en), .rrow(rd_row), .rdata(rd_wide)
  );

  nwm_read_select #(
    .LOG_W(LOG_W), .LANES(LANES), .LANE_BITS(LANE_BITS)
  ) u_rsel (
    .clk(clk), .rst_n(rst_n), .re(rd_en),
    .lane_in(rd_addr[LANE_BITS-1:0]), .row_data(rd_wide),
    .lane_q(rd_lane_q), .word(rd_data)
  );
endmodule

// File: rtl/nwm_checker.sv
module nwm_checker #(
  parameter int LOG_W     = 2,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 2,
  parameter int ADDR_W    = 8,
  localparam int ROW_W    = ADDR_W - LANE_BITS,
  localparam int PW       = LOG_W * LANES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [LOG_W-1:0]     wr_data,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [LOG_W-1:0]     rd_data,
  input logic [ROW_W-1:0]     wr_row,
  input logic [PW-1:0]        wr_wide,
  input logic [LANES-1:0]     wr_mask,
  input logic [LANE_BITS-1:0] rd_lane_q
);
  logic [PW-1:0] placed_back;
  assign placed_back = wr_wide >> (int'(wr_addr[LANE_BITS-1:0]) * LOG_W);

  AST_MASK_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_mask) == 1 && wr_mask[wr_addr[LANE_BITS-1:0]])); // R3
  AST_WORD_IN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> placed_back[LOG_W-1:0] == wr_data); // R3
  AST_IDLE_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_mask == '0); // R4
  AST_ROW_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_row == wr_addr[ADDR_W-1:LANE_BITS])); // R2
  AST_LANE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_lane_q == $past(rd_addr[LANE_BITS-1:0])); // R5
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R6
endmodule

bind narrow_wide_mem nwm_checker #(
  .LOG_W(LOG_W), .LANES(LANES), .LANE_BITS(LANE_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_row(wr_row), .wr_wide(wr_wide), .wr_mask(wr_mask), .rd_lane_q(rd_lane_q)
);

// File: tb/tb_narrow_wide_mem.sv
module tb_narrow_wide_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] model [256];

  always #5 clk = ~clk;

  narrow_wide_mem dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, model[a], $sformatf("read addr %0d", a));
  endtask

  function automatic logic [1:0] pat_a(input logic [7:0] a);
    return a[1:0] ^ a[3:2] ^ a[5:4];
  endfunction

  function automatic logic [1:0] pat_b(input logic [7:0] a);
    return ~a[7:6] + a[1:0] + a[2:1];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 2'd0, "during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", rd_data, 2'd0, "after reset");

    // R2 / R5: full sweep, pattern A
    for (int a = 0; a < 256; a++) do_write(8'(a), pat_a(8'(a)));
    for (int a = 0; a < 256; a++) do_read(8'(a), "R2");
    // R2 / R5: full sweep, pattern B
    for (int a = 0; a < 256; a++) do_write(8'(a), pat_b(8'(a)));
    for (int a = 0; a < 256; a++) do_read(8'(a), "R5");

    // R3: one lane written, neighbours untouched
    foreach (model[i]) if (i < 0) model[i] = '0;
    for (int r = 0; r < 3; r++) begin
      int row;
      row = (r == 0) ? 0 : (r == 1) ? 37 : 63;
      for (int ln = 0; ln < 4; ln++) begin
        for (int k = 0; k < 4; k++) do_write(8'(row * 4 + k), 2'd0);
        do_write(8'(row * 4 + ln), 2'd3);
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          rd_en = 1'b1; rd_addr = 8'(row * 4 + k);
          @(negedge clk);
          rd_en = 1'b0;
          check("R3", rd_data, (k == ln) ? 2'd3 : 2'd0,
                $sformatf("row %0d lane %0d after writing lane %0d", row, k, ln));
        end
      end
    end

    // R4: write with enable low is ignored
    do_write(8'd100, 2'd1);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 8'd100; wr_data = 2'd2;
    @(negedge clk);
    wr_addr = 8'd101; wr_data = 2'd3;
    @(negedge clk);
    do_read(8'd100, "R4");
    do_read(8'd101, "R4");

    // R6: output holds while rd_en is low
    do_write(8'd200, 2'd2);
    do_write(8'd201, 2'd1);
    do_read(8'd200, "R6");
    @(negedge clk);
    rd_addr = 8'd201;
    repeat (3) @(negedge clk);
    check("R6", rd_data, 2'd2, "hold with rd_en low");

    // R7: same-edge read and write return old contents
    do_write(8'd77, 2'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd77; wr_data = 2'd2;
    rd_en = 1'b1; rd_addr = 8'd77;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R7", rd_data, 2'd1, "same-edge read sees old word");
    model[77] = 2'd2;
    do_read(8'd77, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule